// File: doc/BRIEF.md
# Serial LED Chain Output Controller

This block drives a cascade of external serial-in, parallel-out shift registers, which are typically used for LEDs or slow general outputs. Software reaches it through a small register bus. It writes an output word there and can request a transfer. The block then sends the enabled part of the word out on three pins: serial data, shift clock and store strobe. The outputs of all external registers change together on the store strobe.

Some of the low eight output positions can be handed to on-chip status inputs: a two-bit modem status and two three-bit PHY status buses. Those positions then show the live hardware state instead of the software word. To keep such positions current, a periodic refresh can be enabled. It runs at one of four low rates, derived from the bus clock frequency given as a parameter. The edge on which the external registers capture can be chosen as rising or falling.

Top module: `ledchain_ctrl`

## Requirements
- R1: After reset, reads return 0x0400_0000 at offset 0x00 and zero at offsets 0x04, 0x08, 0x0C and 0x10, and any other offset reads zero. The idle pins are sh_clk=1, sh_data=0 and sh_store=0. The registers at offsets 0x04, 0x0C and 0x10 read back what was written to them.
- R2: Bits [2:0] at offset 0x04 enable output groups 0 to 2. A frame shifts 8*(h+1) bits, where h is the highest enabled group. With no group enabled, a frame is a single store pulse with no clock pulse.
- R3: Bits leave most significant first. Each bit takes two cycles: in the first the clock is at its idle level with the data valid, in the second the clock is at its active level with the same data. Bit 26 at offset 0x00 set means the clock idles high and the capture edge is falling. Bit 26 clear means the clock idles low and the capture edge is rising.
- R4: After the last bit, sh_store is high for exactly one cycle while the clock is at its idle level.
- R5: Writing offset 0x00 with bit 31 set requests a frame. Bit 31 then reads 1 until that frame's store pulse has been issued, and reads 0 afterwards. Writing bit 31 as 0 starts no frame.
- R6: A request written while a frame is in progress is held and served by a second frame after the current one.
- R7: Bits [25:24] at offset 0x00 hand output positions 1:0 to modem_st[1:0] instead of the data word at offset 0x08.
- R8: Bits [29:27] at offset 0x00 hand output positions 4:2 to phy_a_st[2:0]. Bits [17:15] at offset 0x04 hand positions 7:5 to phy_b_st[2:0].
- R9: The data word and the status inputs are captured when a frame starts. Changes made during the frame do not affect the bits being shifted.
- R10: With bit 31 at offset 0x04 set, a frame starts every CLK_HZ/rate cycles. The rate comes from bits [24:23]: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 10. With bit 31 clear, no periodic frame occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| modem_st | input | 2 | Modem status bits for output positions 1:0 |
| phy_a_st | input | 3 | First PHY status bits for positions 4:2 |
| phy_b_st | input | 3 | Second PHY status bits for positions 7:5 |
| sh_data | output | 1 | Serial data to the register chain |
| sh_clk | output | 1 | Shift clock to the register chain |
| sh_store | output | 1 | Store strobe to the register chain |

## Verification
The bench sweeps all eight group masks under both clock polarities. A design that took the frame length from the lowest enabled group, or that shifted LSB first, would deliver the wrong bit count or a mirrored word. It also walks every combination of modem and PHY ownership masks, which would expose a hand-over field mapped to the wrong positions. Further tests change the data word and the status inputs in the middle of a frame, and trigger a second request during a frame. These catch live sampling and dropped requests. The refresh period is measured at all four rates, so a timer that is one cycle off or that decodes the rate field wrongly shows up as a wrong interval between store pulses.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CFG_A  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG_B  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_WORD_A = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_WORD_B = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_GATE   = 5'h10;

  // field positions
  localparam int POS_TRIG    = 31;  // cfg_a: software request
  localparam int POS_EDGE    = 26;  // cfg_a: 1 = falling capture edge
  localparam int POS_MODEM   = 24;  // cfg_a: two modem ownership bits
  localparam int POS_PHY_A   = 27;  // cfg_a: three PHY A ownership bits
  localparam int POS_PHY_B   = 15;  // cfg_b: three PHY B ownership bits
  localparam int POS_RATE    = 23;  // cfg_b: two-bit refresh rate
  localparam int POS_AUTO    = 31;  // cfg_b: periodic refresh enable
  localparam int MODEM_W     = 2;
  localparam int PHY_W       = 3;
  localparam int GROUP_W     = 8;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_STORE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/ledchain_regs.sv
module ledchain_regs
  import ledchain_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  localparam int WORD_W = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  frame_start,
  input  logic                  frame_done,
  input  logic                  auto_tick,
  output logic                  req_any,
  output logic                  sw_busy,
  output logic                  edge_fall,
  output logic [MODEM_W-1:0]    own_modem,
  output logic [PHY_W-1:0]      own_phy_a,
  output logic [PHY_W-1:0]      own_phy_b,
  output logic [NUM_GROUPS-1:0] grp_en,
  output logic                  auto_en,
  output logic [1:0]            rate_sel,
  output logic [WORD_W-1:0]     word_a
);
  localparam logic [DATA_W-1:0] CFG_A_RST = DATA_W'(1) << POS_EDGE;

  logic [DATA_W-1:0] cfg_a_q, cfg_a_d, cfg_b_q, cfg_b_d;
  logic [DATA_W-1:0] word_a_q, word_a_d, word_b_q, word_b_d, gate_q, gate_d;
  logic sw_pend_q, sw_pend_d, sw_act_q, sw_act_d, auto_pend_q, auto_pend_d;

  always_comb begin
    cfg_a_d     = cfg_a_q;
    cfg_b_d     = cfg_b_q;
    word_a_d    = word_a_q;
    word_b_d    = word_b_q;
    gate_d      = gate_q;
    sw_pend_d   = sw_pend_q;
    sw_act_d    = sw_act_q;
    auto_pend_d = auto_pend_q;
    if (frame_start) begin
      sw_act_d    = sw_pend_q;
      sw_pend_d   = 1'b0;
      auto_pend_d = 1'b0;
    end
    if (frame_done) sw_act_d = 1'b0;
    if (auto_tick) auto_pend_d = 1'b1;
    if (bus_wr) begin
      case (bus_addr)
        OFS_CFG_A: begin
          cfg_a_d = {1'b0, bus_wdata[DATA_W-2:0]};
          if (bus_wdata[POS_TRIG]) sw_pend_d = 1'b1;
        end
        OFS_CFG_B:  cfg_b_d  = bus_wdata;
        OFS_WORD_A: word_a_d = bus_wdata;
        OFS_WORD_B: word_b_d = bus_wdata;
        OFS_GATE:   gate_d   = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_q     <= CFG_A_RST;
      cfg_b_q     <= '0;
      word_a_q    <= '0;
      word_b_q    <= '0;
      gate_q      <= '0;
      sw_pend_q   <= 1'b0;
      sw_act_q    <= 1'b0;
      auto_pend_q <= 1'b0;
    end else begin
      cfg_a_q     <= cfg_a_d;
      cfg_b_q     <= cfg_b_d;
      word_a_q    <= word_a_d;
      word_b_q    <= word_b_d;
      gate_q      <= gate_d;
      sw_pend_q   <= sw_pend_d;
      sw_act_q    <= sw_act_d;
      auto_pend_q <= auto_pend_d;
    end
  end

  assign sw_busy = sw_pend_q | sw_act_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CFG_A:  bus_rdata = {sw_busy, cfg_a_q[DATA_W-2:0]};
        OFS_CFG_B:  bus_rdata = cfg_b_q;
        OFS_WORD_A: bus_rdata = word_a_q;
        OFS_WORD_B: bus_rdata = word_b_q;
        OFS_GATE:   bus_rdata = gate_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign req_any   = sw_pend_q | auto_pend_q;
  assign edge_fall = cfg_a_q[POS_EDGE];
  assign own_modem = cfg_a_q[POS_MODEM +: MODEM_W];
  assign own_phy_a = cfg_a_q[POS_PHY_A +: PHY_W];
  assign own_phy_b = cfg_b_q[POS_PHY_B +: PHY_W];
  assign grp_en    = cfg_b_q[NUM_GROUPS-1:0];
  assign auto_en   = cfg_b_q[POS_AUTO];
  assign rate_sel  = cfg_b_q[POS_RATE +: 2];
  assign word_a    = word_a_q[WORD_W-1:0];
endmodule

// File: rtl/ledchain_rate.sv
module ledchain_rate #(
  parameter int CLK_HZ = 50_000_000,
  localparam int LIM_2  = CLK_HZ / 2 - 1,
  localparam int LIM_4  = CLK_HZ / 4 - 1,
  localparam int LIM_8  = CLK_HZ / 8 - 1,
  localparam int LIM_10 = CLK_HZ / 10 - 1,
  localparam int CW     = $clog2(LIM_2 + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    case (rate_sel)
      2'b00:   limit = CW'(LIM_2);
      2'b01:   limit = CW'(LIM_4);
      2'b10:   limit = CW'(LIM_8);
      default: limit = CW'(LIM_10);
    endcase
  end

  assign tick = enable && (cnt_q >= limit);

  always_comb begin
    if (!enable || cnt_q >= limit) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ledchain_shift.sv
module ledchain_shift
  import ledchain_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  localparam int WORD_W = NUM_GROUPS * GROUP_W,
  localparam int IDXW   = $clog2(WORD_W),
  localparam int CNTW   = $clog2(WORD_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [NUM_GROUPS-1:0] grp_en,
  input  logic                  edge_fall,
  input  logic [WORD_W-1:0]     word_in,
  output logic                  start,
  output logic                  done,
  output logic                  busy,
  output logic                  sh_data,
  output logic                  sh_clk,
  output logic                  sh_store
);
  eng_state_e        state_q, state_d;
  logic [IDXW-1:0]   idx_q, idx_d;
  logic              phase_q, phase_d, pol_q, pol_d;
  logic [WORD_W-1:0] frame_q, frame_d;
  logic [CNTW-1:0]   nbits;

  // length set by the highest enabled group
  always_comb begin
    nbits = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (grp_en[g]) nbits = CNTW'((g + 1) * GROUP_W);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    phase_d = phase_q;
    pol_d   = pol_q;
    frame_d = frame_q;
    start   = 1'b0;
    done    = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        pol_d = edge_fall;
        if (go) begin
          start   = 1'b1;
          frame_d = word_in;
          phase_d = 1'b0;
          idx_d   = IDXW'(nbits - 1'b1);
          state_d = (nbits == '0) ? ENG_STORE : ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        if (!phase_q) begin
          phase_d = 1'b1;
        end else if (idx_q == '0) begin
          state_d = ENG_STORE;
        end else begin
          idx_d   = idx_q - 1'b1;
          phase_d = 1'b0;
        end
      end
      ENG_STORE: begin
        done    = 1'b1;
        state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      phase_q <= 1'b0;
      pol_q   <= 1'b1;
      frame_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      phase_q <= phase_d;
      pol_q   <= pol_d;
      frame_q <= frame_d;
    end
  end

  assign busy     = (state_q != ENG_IDLE);
  assign sh_store = (state_q == ENG_STORE);
  assign sh_clk   = pol_q ^ ((state_q == ENG_SHIFT) && phase_q);
  assign sh_data  = (state_q == ENG_SHIFT) ? frame_q[idx_q] : 1'b0;
endmodule

// File: rtl/ledchain_ctrl.sv
module ledchain_ctrl
  import ledchain_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int NUM_GROUPS = 3,
  localparam int WORD_W    = NUM_GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [MODEM_W-1:0] modem_st,
  input  logic [PHY_W-1:0]   phy_a_st,
  input  logic [PHY_W-1:0]   phy_b_st,
  output logic               sh_data,
  output logic               sh_clk,
  output logic               sh_store
);
  logic rst_meta, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_core_n, rst_meta} <= 2'b00;
    else        {rst_core_n, rst_meta} <= {rst_meta, 1'b1};
  end

  logic                  frame_start, frame_done, auto_tick, req_any;
  logic                  sw_busy, eng_busy, edge_fall, auto_en;
  logic [MODEM_W-1:0]    own_modem;
  logic [PHY_W-1:0]      own_phy_a, own_phy_b;
  logic [NUM_GROUPS-1:0] grp_en;
  logic [1:0]            rate_sel;
  logic [WORD_W-1:0]     word_a, merged;

  ledchain_regs #(.NUM_GROUPS(NUM_GROUPS)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_start(frame_start), .frame_done(frame_done), .auto_tick(auto_tick),
    .req_any(req_any), .sw_busy(sw_busy), .edge_fall(edge_fall),
    .own_modem(own_modem), .own_phy_a(own_phy_a), .own_phy_b(own_phy_b),
    .grp_en(grp_en), .auto_en(auto_en), .rate_sel(rate_sel), .word_a(word_a)
  );

  ledchain_rate #(.CLK_HZ(CLK_HZ)) u_rate (
    .clk(clk), .rst_n(rst_core_n), .enable(auto_en),
    .rate_sel(rate_sel), .tick(auto_tick)
  );

  // hardware-owned positions replace the software word
  always_comb begin
    merged = word_a;
    for (int k = 0; k < MODEM_W; k++)
      if (own_modem[k]) merged[k] = modem_st[k];
    for (int k = 0; k < PHY_W; k++) begin
      if (own_phy_a[k]) merged[MODEM_W + k]         = phy_a_st[k];
      if (own_phy_b[k]) merged[MODEM_W + PHY_W + k] = phy_b_st[k];
    end
  end

  ledchain_shift #(.NUM_GROUPS(NUM_GROUPS)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .go(req_any), .grp_en(grp_en),
    .edge_fall(edge_fall), .word_in(merged),
    .start(frame_start), .done(frame_done), .busy(eng_busy),
    .sh_data(sh_data), .sh_clk(sh_clk), .sh_store(sh_store)
  );
endmodule

// File: rtl/ledchain_chk.sv
module ledchain_chk (
  input logic clk,
  input logic rst_n,
  input logic sh_store,
  input logic sw_busy,
  input logic eng_busy,
  input logic auto_en,
  input logic auto_tick
);
  // R4: store strobe lasts one cycle
  a_r4_store_single: assert property (@(posedge clk) disable iff (!rst_n)
    sh_store |=> !sh_store);

  // R5: request status clears only right after a store pulse
  a_r5_clear_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_busy) |-> $past(sh_store));

  // R6: a pending request seen by an idle engine starts a frame next cycle
  a_r6_pending_served: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_busy && !eng_busy) |=> eng_busy);

  // R10: no refresh tick while periodic refresh is disabled
  a_r10_no_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> !auto_tick);
endmodule

bind ledchain_ctrl ledchain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sh_store(sh_store), .sw_busy(sw_busy),
  .eng_busy(eng_busy), .auto_en(auto_en), .auto_tick(auto_tick)
);

// File: tb/ledchain_ctrl_tb.sv
module ledchain_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ      = 400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  modem_st;
  logic [2:0]  phy_a_st, phy_b_st;
  logic        sh_data, sh_clk, sh_store;

  int checks = 0, errors = 0;

  ledchain_ctrl #(.CLK_HZ(TB_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .modem_st(modem_st), .phy_a_st(phy_a_st), .phy_b_st(phy_b_st),
    .sh_data(sh_data), .sh_clk(sh_clk), .sh_store(sh_store)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // frame monitor on the pins
  logic        cur_pol = 1'b1, prev_clk = 1'b1;
  logic [31:0] acc = '0, last_word = '0;
  int cnt = 0, last_cnt = 0, frames = 0, cycle = 0;
  int last_store_cyc = 0, prev_store_cyc = 0, store_clk_bad = 0;

  always @(negedge clk) begin
    cycle++;
    if (sh_store) begin
      last_word = acc; last_cnt = cnt; acc = '0; cnt = 0; frames++;
      prev_store_cyc = last_store_cyc; last_store_cyc = cycle;
      if (sh_clk !== cur_pol) store_clk_bad++;
    end else if (sh_clk !== cur_pol && prev_clk === cur_pol) begin
      acc = {acc[30:0], sh_data}; cnt++;
    end
    prev_clk = sh_clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_frame(input string req);
    int tgt = frames + 1;
    int n = 0;
    while (frames < tgt && n < 500) begin @(negedge clk); n++; end
    chk(req, 32'(frames >= tgt), 32'd1);
  endtask

  logic [31:0] cfg_a_val;

  task automatic fire(input string req);
    wr(5'h00, cfg_a_val | 32'h8000_0000);
    wait_frame(req);
  endtask

  function automatic int nb(input int g);
    return g[2] ? 24 : g[1] ? 16 : g[0] ? 8 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, w, own, st, expw;
    int f;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    modem_st = '0; phy_a_st = '0; phy_b_st = '0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and readback
    rd(5'h00, d); chk("R1 cfg_a reset", d, 32'h0400_0000);
    rd(5'h04, d); chk("R1 cfg_b reset", d, 0);
    rd(5'h08, d); chk("R1 word_a reset", d, 0);
    rd(5'h0C, d); chk("R1 word_b reset", d, 0);
    rd(5'h10, d); chk("R1 gate reset", d, 0);
    chk("R1 idle pins", {29'd0, sh_clk, sh_data, sh_store}, 32'h4);
    wr(5'h0C, 32'h1234_5678); rd(5'h0C, d); chk("R1 word_b rb", d, 32'h1234_5678);
    wr(5'h10, 32'hCAFE_0001); rd(5'h10, d); chk("R1 gate rb", d, 32'hCAFE_0001);
    wr(5'h04, 32'h0001_8005); rd(5'h04, d); chk("R1 cfg_b rb", d, 32'h0001_8005);
    rd(5'h14, d); chk("R1 unmapped", d, 0);

    // R2 R3 R4: all group masks, both polarities
    for (int p = 1; p >= 0; p--) begin
      cur_pol = p[0];
      cfg_a_val = 32'(p) << 26;
      wr(5'h00, cfg_a_val);
      repeat (3) @(negedge clk);
      chk("R3 idle level", {31'd0, sh_clk}, 32'(p));
      for (int g = 0; g < 8; g++) begin
        w = 32'hA5C3_96E1 ^ (32'(g) * 32'h0011_1111) ^ (32'(p) << 20);
        wr(5'h04, 32'(g));
        wr(5'h08, w);
        fire("R5 frame");
        chk("R2 bit count", 32'(last_cnt), 32'(nb(g)));
        expw = (nb(g) == 0) ? 0 : (w & ((32'd1 << nb(g)) - 1));
        chk("R3 msb first word", last_word, expw);
      end
    end
    chk("R4 clock idle at store", 32'(store_clk_bad), 0);

    // R5 status and write-zero
    cur_pol = 1'b1; cfg_a_val = 32'h0400_0000;
    wr(5'h00, cfg_a_val); wr(5'h04, 32'h1);
    wr(5'h00, cfg_a_val | 32'h8000_0000);
    rd(5'h00, d); chk("R5 busy bit set", d, 32'h8400_0000);
    wait_frame("R5 frame");
    rd(5'h00, d); chk("R5 busy bit clear", d, 32'h0400_0000);
    f = frames; wr(5'h00, cfg_a_val); repeat (40) @(negedge clk);
    chk("R5 zero write no frame", 32'(frames), 32'(f));

    // R6 request during a frame
    f = frames;
    wr(5'h00, cfg_a_val | 32'h8000_0000);
    repeat (4) @(negedge clk);
    wr(5'h00, cfg_a_val | 32'h8000_0000);
    repeat (80) @(negedge clk);
    chk("R6 second frame", 32'(frames), 32'(f + 2));

    // R7 R8: every ownership combination
    modem_st = 2'b01; phy_a_st = 3'b110; phy_b_st = 3'b011;
    st = 32'h01 | (32'h6 << 2) | (32'h3 << 5);
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          cfg_a_val = 32'h0400_0000 | (32'(m) << 24) | (32'(a) << 27);
          w = 32'h0000_005A ^ 32'(m * 7 + a * 3 + b * 29);
          wr(5'h04, 32'h1 | (32'(b) << 15));
          wr(5'h08, w);
          fire("R7 frame");
          own = 32'(m) | (32'(a) << 2) | (32'(b) << 5);
          expw = ((w & ~own) | (st & own)) & 32'hFF;
          chk("R7 R8 merged word", last_word, expw);
        end

    // R9 snapshot of word and status
    cfg_a_val = 32'h0400_0000; wr(5'h04, 32'h1); wr(5'h08, 32'h5A);
    wr(5'h00, cfg_a_val | 32'h8000_0000);
    repeat (4) @(negedge clk);
    wr(5'h08, 32'hFF);
    wait_frame("R9 frame");
    chk("R9 word snapshot", last_word, 32'h5A);
    cfg_a_val = 32'h0700_0000; modem_st = 2'b00; wr(5'h08, 32'h0);
    wr(5'h00, cfg_a_val | 32'h8000_0000);
    repeat (4) @(negedge clk);
    modem_st = 2'b11;
    wait_frame("R9 frame");
    chk("R9 status snapshot", last_word, 32'h0);

    // R10 periodic refresh at each rate
    cfg_a_val = 32'h0400_0000; wr(5'h00, cfg_a_val);
    for (int r = 0; r < 4; r++) begin
      wr(5'h04, 32'h8000_0001 | (32'(r) << 23));
      wait_frame("R10 auto"); wait_frame("R10 auto"); wait_frame("R10 auto");
      chk("R10 period", 32'(last_store_cyc - prev_store_cyc),
          32'(TB_HZ / (r == 0 ? 2 : r == 1 ? 4 : r == 2 ? 8 : 10)));
    end
    wr(5'h04, 32'h1);
    repeat (30) @(negedge clk);
    f = frames;
    repeat (450) @(negedge clk);
    chk("R10 disabled", 32'(frames), 32'(f));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule